// File: doc/BRIEF.md
# Modem Status Scanner

This block is the modem-control side of a 16-line serial multiplexer. For every line it holds three output levels (line enable, data-terminal-ready and request-to-send) and watches one input, carrier detect, through a two-flop synchroniser. Software reaches this state through two 16-bit registers. The control word picks a line. The line word reads and writes the modem bits of the line that is picked.

When software enables scanning, a step counter moves the line number forward by one line every `SCAN_DIV` clocks. At the end of each step it compares the synchronised carrier of the current line with a remembered copy. If they differ, the scan stops on that line. The remembered copy takes the new level, and the block raises a done bit and a carrier-change flag. The interrupt is the level of done gated by interrupt-enable. Software reads the line number to find the line that changed. It then writes scan-enable and interrupt-enable together to resume.

Before it touches the line select or the line word, software must clear scan-enable and wait for the busy flag to fall. While the scan owns the line number, writes to either are ignored.

Top module: `modem_scanner`

## Requirements
- R1: After reset, both registers read zero, every line-enable, DTR and RTS output is low and the interrupt is low.
- R2: The control word (regSel=0) reads line number in bits 3:0, busy in bit 4, scan-enable in bit 5, interrupt-enable in bit 6, done in bit 7, carrier-change flag in bit 15, and zero elsewhere. Busy is high while a scan step is part-way through.
- R3: A control write updates the line number, and a line-word write is accepted, only when scan-enable and busy are both low at the write. Otherwise the line number and all per-line outputs keep their values.
- R4: The line word (regSel=1) holds line-enable in bit 0, DTR in bit 1 and RTS in bit 2. A write drives these three outputs of the selected line only. Bit 6 reads the carrier of the selected line two clocks after the input changes, and writes to bit 6 are ignored.
- R5: With scan-enable high and done low, the line number advances by one, modulo 16, every 8 clocks, counted from the write that sets scan-enable.
- R6: At the end of a step, if the synchronised carrier differs from the remembered copy for that line, done and the carrier-change flag set and the line number stays. The copy takes the new level, so that change is not reported again. The scan stays frozen until resumed.
- R7: Clearing scan-enable mid-step lets the step finish: busy stays high until the step ends, the line number then advances once, and afterwards busy stays low and the line number is stable.
- R8: A control write with bits 5 and 6 both set clears done and the carrier-change flag and resumes scanning.
- R9: A control write with bit 7 set and bits 5 and 6 not both set sets done without setting the carrier-change flag. A write with bit 7 clear clears done and the flag.
- R10: The interrupt output is high exactly while done and interrupt-enable are both high.
- R11: When a step end detects a change in the same cycle as a control write that would clear done, done and the carrier-change flag still end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 1 | Register select: 0 control word, 1 line word |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the selected register (combinational) |
| carrierIn | input | 16 | Carrier detect, one per line, asynchronous |
| lineOn | output | 16 | Line enable, one per line |
| dtr | output | 16 | Data-terminal-ready, one per line |
| rts | output | 16 | Request-to-send, one per line |
| irq | output | 1 | Interrupt, level |

## Verification
Two events can land on the same clock edge: the end of a scan step that finds a carrier change, and a host write to the control word that tries to clear done. The bench starts a scan on a line whose carrier was raised beforehand, counts seven clocks, and times a done-clearing control write so the same edge captures it and the step end. The result is judged from the control word: done and the flag must both read set, the line number must stay on that line, and the write's own enable bits must have taken effect.

// File: rtl/modem_scan_pkg.sv
package modem_scan_pkg;

  localparam int REG_W = 16;

  // control word bit positions
  localparam int CTL_BUSY  = 4;
  localparam int CTL_SCAN  = 5;
  localparam int CTL_IEN   = 6;
  localparam int CTL_DONE  = 7;
  localparam int CTL_CFLAG = 15;

  // line word bit positions
  localparam int STS_ON  = 0;
  localparam int STS_DTR = 1;
  localparam int STS_RTS = 2;
  localparam int STS_CAR = 6;

  // strobes from the sequencer to the per-line datapath
  typedef struct packed {
    logic stepEnd;   // last clock of a scan step
    logic lineWr;    // accepted write of the line word
  } scanStrobe_t;

endpackage

// File: rtl/modem_scan_ctrl.sv
module modem_scan_ctrl
  import modem_scan_pkg::*;
#(
  parameter int SEL_W    = 4,
  parameter int SCAN_DIV = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWr,
  input  logic             stsWr,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             wrScan,
  input  logic             wrIen,
  input  logic             wrDone,
  input  logic             changeHit,
  output scanStrobe_t      strobe,
  output logic [SEL_W-1:0] lineSel,
  output logic             scanEn,
  output logic             intEn,
  output logic             done,
  output logic             cflag,
  output logic             busy,
  output logic             irq
);

  localparam int CNT_W = (SCAN_DIV > 2) ? $clog2(SCAN_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SCAN_DIV - 1);

  logic [CNT_W-1:0] divCnt;
  logic             run;
  logic             lastStep;
  logic             regOpen;
  logic             resume;

  assign busy     = (divCnt != '0);
  assign lastStep = (divCnt == LAST_CNT);
  // a started step always completes, even after scan-enable drops
  assign run      = (scanEn && !done) || busy;
  assign regOpen  = !scanEn && !busy;
  assign resume   = wrScan && wrIen;

  assign strobe.stepEnd = run && lastStep;
  assign strobe.lineWr  = stsWr && regOpen;

  assign irq = done && intEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      lineSel <= '0;
      scanEn  <= 1'b0;
      intEn   <= 1'b0;
      done    <= 1'b0;
      cflag   <= 1'b0;
    end else begin
      if (run) begin
        divCnt <= lastStep ? '0 : divCnt + 1'b1;
      end

      if (ctlWr) begin
        scanEn <= wrScan;
        intEn  <= wrIen;
        if (resume) begin
          done  <= 1'b0;
          cflag <= 1'b0;
        end else begin
          done <= wrDone;
          if (!wrDone) begin
            cflag <= 1'b0;
          end
        end
        if (regOpen) begin
          lineSel <= wrSel;
        end
      end

      // step result comes last so a detection outranks a host clear
      if (strobe.stepEnd) begin
        if (changeHit) begin
          done  <= 1'b1;
          cflag <= 1'b1;
        end else begin
          lineSel <= lineSel + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/modem_scan_dpath.sv
module modem_scan_dpath
  import modem_scan_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scanStrobe_t          strobe,
  input  logic [SEL_W-1:0]     lineSel,
  input  logic [2:0]           wrBits,
  input  logic [NUM_LINES-1:0] carrierIn,
  output logic [NUM_LINES-1:0] lineOn,
  output logic [NUM_LINES-1:0] dtr,
  output logic [NUM_LINES-1:0] rts,
  output logic [2:0]           selBits,
  output logic                 selCarrier,
  output logic                 changeHit
);

  logic [NUM_LINES-1:0] syncA;
  logic [NUM_LINES-1:0] syncB;
  logic [NUM_LINES-1:0] seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      seen  <= '0;
    end else begin
      syncA <= carrierIn;
      syncB <= syncA;
      if (strobe.stepEnd && changeHit) begin
        seen[lineSel] <= syncB[lineSel];
      end
    end
  end

  assign changeHit  = syncB[lineSel] ^ seen[lineSel];
  assign selCarrier = syncB[lineSel];
  assign selBits    = {rts[lineSel], dtr[lineSel], lineOn[lineSel]};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [2:0] bitsQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bitsQ <= '0;
      end else if (strobe.lineWr && (lineSel == SEL_W'(i))) begin
        bitsQ <= wrBits;
      end
    end
    assign lineOn[i] = bitsQ[0];
    assign dtr[i]    = bitsQ[1];
    assign rts[i]    = bitsQ[2];
  end

endmodule

// File: rtl/modem_scanner.sv
module modem_scanner
  import modem_scan_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int SCAN_DIV  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regSel,
  input  logic                 wrEn,
  input  logic [REG_W-1:0]     wrData,
  output logic [REG_W-1:0]     rdData,
  input  logic [NUM_LINES-1:0] carrierIn,
  output logic [NUM_LINES-1:0] lineOn,
  output logic [NUM_LINES-1:0] dtr,
  output logic [NUM_LINES-1:0] rts,
  output logic                 irq
);

  localparam int SEL_W = $clog2(NUM_LINES);

  scanStrobe_t      strobe;
  logic [SEL_W-1:0] lineSel;
  logic             scanEn;
  logic             intEn;
  logic             done;
  logic             cflag;
  logic             busy;
  logic             changeHit;
  logic [2:0]       selBits;
  logic             selCarrier;
  logic [REG_W-1:0] rdCtl;
  logic [REG_W-1:0] rdSts;
  logic             unusedWr;

  assign unusedWr = ^{wrData[REG_W-1:CTL_DONE+1], wrData[CTL_BUSY]};

  modem_scan_ctrl #(
    .SEL_W   (SEL_W),
    .SCAN_DIV(SCAN_DIV)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctlWr    (wrEn && !regSel),
    .stsWr    (wrEn && regSel),
    .wrSel    (wrData[SEL_W-1:0]),
    .wrScan   (wrData[CTL_SCAN]),
    .wrIen    (wrData[CTL_IEN]),
    .wrDone   (wrData[CTL_DONE]),
    .changeHit(changeHit),
    .strobe   (strobe),
    .lineSel  (lineSel),
    .scanEn   (scanEn),
    .intEn    (intEn),
    .done     (done),
    .cflag    (cflag),
    .busy     (busy),
    .irq      (irq)
  );

  modem_scan_dpath #(
    .NUM_LINES(NUM_LINES),
    .SEL_W    (SEL_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lineSel   (lineSel),
    .wrBits    ({wrData[STS_RTS], wrData[STS_DTR], wrData[STS_ON]}),
    .carrierIn (carrierIn),
    .lineOn    (lineOn),
    .dtr       (dtr),
    .rts       (rts),
    .selBits   (selBits),
    .selCarrier(selCarrier),
    .changeHit (changeHit)
  );

  always_comb begin
    rdCtl = '0;
    rdCtl[SEL_W-1:0] = lineSel;
    rdCtl[CTL_BUSY]  = busy;
    rdCtl[CTL_SCAN]  = scanEn;
    rdCtl[CTL_IEN]   = intEn;
    rdCtl[CTL_DONE]  = done;
    rdCtl[CTL_CFLAG] = cflag;

    rdSts = '0;
    rdSts[STS_ON]  = selBits[0];
    rdSts[STS_DTR] = selBits[1];
    rdSts[STS_RTS] = selBits[2];
    rdSts[STS_CAR] = selCarrier;

    rdData = regSel ? rdSts : rdCtl;
  end

endmodule

// File: rtl/modem_scanner_chk.sv
module modem_scanner_chk #(
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regSel,
  input logic                 wrEn,
  input logic [SEL_W-1:0]     lineSel,
  input logic                 scanEn,
  input logic                 done,
  input logic                 cflag,
  input logic                 busy,
  input logic [NUM_LINES-1:0] lineOn,
  input logic [NUM_LINES-1:0] dtr,
  input logic [NUM_LINES-1:0] rts
);

  logic ctlWrite;
  logic stsWrite;
  assign ctlWrite = wrEn && !regSel;
  assign stsWrite = wrEn && regSel;

  // R5
  sel_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWrite |=> (lineSel == $past(lineSel)) ||
                  (lineSel == SEL_W'($past(lineSel) + 1'b1)));

  // R6
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !busy && !ctlWrite) |=> $stable(lineSel));

  // R6
  flag_on_detect_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWrite |=> (!$rose(done) || cflag));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!scanEn && !busy && !ctlWrite) |=> !busy);

  // R3
  locked_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stsWrite && (scanEn || busy)) |=> $stable({lineOn, dtr, rts}));

  // R4
  lines_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stsWrite |=> $stable({lineOn, dtr, rts}));

endmodule

bind modem_scanner modem_scanner_chk #(
  .NUM_LINES(NUM_LINES),
  .SEL_W    (SEL_W)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .regSel (regSel),
  .wrEn   (wrEn),
  .lineSel(lineSel),
  .scanEn (scanEn),
  .done   (done),
  .cflag  (cflag),
  .busy   (busy),
  .lineOn (lineOn),
  .dtr    (dtr),
  .rts    (rts)
);

// File: tb/modem_scanner_tb.sv
module modem_scanner_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [15:0] carrierIn = '0;
  logic [15:0] lineOn;
  logic [15:0] dtr;
  logic [15:0] rts;
  logic        irq;

  int nChecks = 0;
  int nFail   = 0;

  logic [15:0] expOn  = '0;
  logic [15:0] expDtr = '0;
  logic [15:0] expRts = '0;

  // {line[3:0], 1'b0, rts, dtr, on}
  localparam logic [7:0] VEC [6] = '{8'h07, 8'hF5, 8'h72, 8'h00, 8'hC4, 8'h33};

  modem_scanner u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .regSel   (regSel),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .rdData   (rdData),
    .carrierIn(carrierIn),
    .lineOn   (lineOn),
    .dtr      (dtr),
    .rts      (rts),
    .irq      (irq)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [47:0] act, input logic [47:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; the next rising edge captures the write
  task automatic hostWrite(input logic a, input logic [15:0] d);
    regSel = a;
    wrData = d;
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    regSel = a;
    #1;
    v = rdData;
  endtask

  task automatic checkCtl(input logic [15:0] exp, input string tag);
    logic [15:0] v;
    rd(1'b0, v);
    check(v == exp, tag, {32'h0, v}, {32'h0, exp});
  endtask

  task automatic checkLines(input string tag);
    check({rts, dtr, lineOn} == {expRts, expDtr, expOn}, tag,
          {rts, dtr, lineOn}, {expRts, expDtr, expOn});
  endtask

  initial begin
    #3_000_000;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nChecks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    checkCtl(16'h0000, "R1 control word");
    rd(1'b1, v);
    check(v == 16'h0000, "R1 line word", {32'h0, v}, 48'h0);
    check({rts, dtr, lineOn} == '0, "R1 outputs", {rts, dtr, lineOn}, 48'h0);
    check(irq == 1'b0, "R1 irq", {47'h0, irq}, 48'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 vector table: select a line, write its modem bits, check all lines
    for (int k = 0; k < 6; k++) begin
      logic [3:0] sel;
      logic [2:0] b;
      sel = VEC[k][7:4];
      b   = VEC[k][2:0];
      hostWrite(1'b0, {12'h000, sel});
      hostWrite(1'b1, {9'h000, 1'b1, 3'b000, b});   // bit 6 write ignored
      expOn[sel]  = b[0];
      expDtr[sel] = b[1];
      expRts[sel] = b[2];
      checkLines("R4 table outputs");
      rd(1'b1, v);
      check(v == {13'h0, b}, "R4 table readback", {32'h0, v}, {45'h0, b});
    end

    // R4 carrier readback through two-flop synchroniser on line 12
    hostWrite(1'b0, 16'h000C);
    checkCtl(16'h000C, "R2 line number field");
    carrierIn[12] = 1'b1;
    @(negedge clk);
    rd(1'b1, v);
    check(v == 16'h0004, "R4 carrier after 1 clock", {32'h0, v}, 48'h0004);
    @(negedge clk);
    rd(1'b1, v);
    check(v == 16'h0044, "R4 carrier after 2 clocks", {32'h0, v}, 48'h0044);

    // R5 stepping from line 0
    hostWrite(1'b0, 16'h0020);
    checkCtl(16'h0020, "R2 scan enabled, not busy");
    @(negedge clk);
    checkCtl(16'h0030, "R2 busy mid-step");
    repeat (6) @(negedge clk);
    checkCtl(16'h0030, "R5 still line 0 after 7 clocks");
    @(negedge clk);
    checkCtl(16'h0021, "R5 line 1 after 8 clocks");
    repeat (2) @(negedge clk);
    // R7 stop mid-step; R3 line number in the same write is ignored
    hostWrite(1'b0, 16'h0000);
    checkCtl(16'h0011, "R3/R7 busy holds, select ignored");
    repeat (4) @(negedge clk);
    checkCtl(16'h0011, "R7 busy until step end");
    @(negedge clk);
    checkCtl(16'h0002, "R7 step finished, advanced once");
    repeat (8) @(negedge clk);
    checkCtl(16'h0002, "R7 idle and stable");

    // R3 line word write while scanning is ignored
    hostWrite(1'b0, 16'h0022);
    hostWrite(1'b1, 16'h0007);
    hostWrite(1'b0, 16'h0000);
    repeat (10) @(negedge clk);
    checkLines("R3 outputs untouched");
    checkCtl(16'h0003, "R3 select ignored while busy");

    // R6 detection on line 5
    hostWrite(1'b0, 16'h0005);
    carrierIn[5] = 1'b1;
    repeat (3) @(negedge clk);
    hostWrite(1'b0, 16'h0065);
    repeat (7) @(negedge clk);
    checkCtl(16'h0075, "R6 before step end");
    check(irq == 1'b0, "R10 irq low before detect", {47'h0, irq}, 48'h0);
    @(negedge clk);
    checkCtl(16'h80E5, "R6 detect sets done and flag");
    check(irq == 1'b1, "R10 irq on detect", {47'h0, irq}, 48'h1);
    repeat (20) @(negedge clk);
    checkCtl(16'h80E5, "R6 scan frozen");

    // R8 resume
    hostWrite(1'b0, 16'h0060);
    checkCtl(16'h0065, "R8 resume clears done and flag");
    check(irq == 1'b0, "R10 irq cleared", {47'h0, irq}, 48'h0);
    repeat (8) @(negedge clk);
    checkCtl(16'h0066, "R6 change not reported again");
    hostWrite(1'b0, 16'h0000);
    repeat (10) @(negedge clk);
    checkCtl(16'h0007, "R7 stop after resume");

    // R11 detection and a done-clearing write on the same edge
    hostWrite(1'b0, 16'h0009);
    carrierIn[9] = 1'b1;
    repeat (3) @(negedge clk);
    hostWrite(1'b0, 16'h0029);
    repeat (7) @(negedge clk);
    hostWrite(1'b0, 16'h0020);
    checkCtl(16'h80A9, "R11 detection wins over clear");
    check(irq == 1'b0, "R10 no irq without enable", {47'h0, irq}, 48'h0);
    hostWrite(1'b0, 16'h00C0);
    checkCtl(16'h80C9, "R9 done kept by write with bit 7");
    check(irq == 1'b1, "R10 irq with enable", {47'h0, irq}, 48'h1);
    hostWrite(1'b0, 16'h0040);
    checkCtl(16'h0040, "R9 write clears done and flag");

    // R9 software-raised done
    hostWrite(1'b0, 16'h00C3);
    checkCtl(16'h00C3, "R9 software done, no flag");
    check(irq == 1'b1, "R9 software irq", {47'h0, irq}, 48'h1);
    hostWrite(1'b0, 16'h0003);
    check(irq == 1'b0, "R9 irq removed", {47'h0, irq}, 48'h0);
    checkLines("R4 outputs at end");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule